// File: doc/BRIEF.md
# Per-Pin Selectable Debounce Filter Bank

This block cleans up a group of slow digital inputs, such as buttons, switches and card-detect lines, before the rest of the chip sees them. Each pin first passes through a two-flop synchronizer. A per-pin filter then reports a new level only after the synchronized input has held that level for an unbroken settling time. Each pin has its own settling time, chosen from seven fixed durations between 1 µs and 30 ms. Durations are counted in 1 µs ticks from a prescaler on the system clock. The clock frequency is a parameter.

Software sets the settling times through 32-bit configuration words on a simple select/write bus. Each word holds eight 4-bit pin fields. The low three bits of a field hold the duration code. The top bit is a write enable, so a single write can change one pin and leave its neighbours untouched, with no read-modify-write. The filtered levels drive the pin outputs directly.

Top module: `dbf_bank`

## Requirements
- R1: After reset every implemented field reads DEFAULT_CODE (3 by default). After reset is released, each filtered output takes the level its raw input held through reset within 3 clock edges, without waiting for a settling time.
- R2: Pin p lives in the word at bus address p/8, with its duration code in bits (p mod 8)*4 to (p mod 8)*4+2 and its write-enable bit at (p mod 8)*4+3.
- R3: A write updates a pin's code only when that pin's write-enable bit is 1 in the written word. Every other field keeps its value, and writes to addresses at or above the number of configuration words change nothing.
- R4: A read returns its data on busRdata one clock after the select cycle. The stored codes appear in their fields, and write-enable bits, fields of pins beyond NUM_PINS and words at unused addresses read 0.
- R5: Codes 0 to 6 select settling times of 1, 10, 100, 1000, 10000, 20000 and 30000 ticks.
- R6: Code 7 is accepted, reads back as 7 and filters like code 6 (30000 ticks).
- R7: With one tick per clock, a raw input change applied between edges first shows on the filtered output at the (L+2)th rising edge after it, where L is the pin's tick count. Other pins are not affected.
- R8: If the synchronized input returns to the filtered level before the settling time ends, the count restarts. The full settling time is then needed again from the input's next change.
- R9: The prescaler issues one tick every CLK_HZ/1000000 clock cycles (at least one), and filter counts advance only on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| pinRaw | input | NUM_PINS | Raw asynchronous pin levels |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Configuration word address |
| busWdata | input | 32 | Write data: code fields and write-enable bits |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| pinFilt | output | NUM_PINS | Debounced pin levels |

## Verification
Two situations are hard to reach from the ports. The first is a bounce that arrives partway through a long count: it has to interrupt the count without ever becoming visible on the output. The second is the 30000-tick window of codes 6 and 7. The bench sets the prescaler to one tick per clock so that even the longest windows complete in the run. It lets a 1000-tick count run halfway, drops the input for a single cycle and brings it back. It then checks that the output still holds one edge before a fresh full window ends and flips on the exact edge that ends it.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  localparam int CNT_W = 15;
  localparam int MAX_TICKS = 30000;

  typedef struct packed {
    logic       cfgWrite;
    logic       cfgRead;
    logic [7:0] regIdx;
    logic       tick;
    logic       seed;
  } dbfStrobe_t;

  function automatic logic [CNT_W-1:0] codeToTicks(input logic [2:0] code);
    case (code)
      3'd0:    return 15'd1;
      3'd1:    return 15'd10;
      3'd2:    return 15'd100;
      3'd3:    return 15'd1000;
      3'd4:    return 15'd10000;
      3'd5:    return 15'd20000;
      default: return 15'd30000;
    endcase
  endfunction

endpackage

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
  import dbf_pkg::*;
#(
  parameter int CLK_HZ   = 1_000_000,
  parameter int ADDR_W   = 4,
  parameter int NUM_REGS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output dbfStrobe_t        strb
);

  localparam int DIV_RAW = CLK_HZ / 1_000_000;
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int PW      = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] preCnt;
  logic [1:0]    seedCnt;
  logic          inRange;

  // tick prescaler (R9)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               preCnt <= '0;
    else if (preCnt == LAST) preCnt <= '0;
    else                     preCnt <= preCnt + 1'b1;
  end

  // seed window: three edges after reset release (R1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 seedCnt <= 2'd0;
    else if (seedCnt != 2'd3)  seedCnt <= seedCnt + 2'd1;
  end

  assign inRange = (32'(busAddr) < NUM_REGS);

  always_comb begin
    strb.cfgWrite = busSel && busWrite && inRange;
    strb.cfgRead  = busSel && !busWrite;
    strb.regIdx   = 8'(busAddr);
    strb.tick     = (preCnt == LAST);
    strb.seed     = (seedCnt != 2'd3);
  end

  a_r1_seed_ends: assert property (@(posedge clk) disable iff (!rstN)
    !strb.seed |=> !strb.seed);

  a_r3_write_in_range: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgWrite |-> (32'(strb.regIdx) < NUM_REGS));

endmodule

// File: rtl/dbf_channel.sv
module dbf_channel
  import dbf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rawIn,
  input  logic       tick,
  input  logic       seed,
  input  logic [2:0] code,
  output logic       filt
);

  logic             syncA, syncB;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cntNext;

  assign limit   = codeToTicks(code);
  assign cntNext = cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      cnt   <= '0;
      filt  <= 1'b0;
    end else begin
      syncA <= rawIn;
      syncB <= syncA;
      if (seed) begin
        filt <= syncB;
        cnt  <= '0;
      end else if (syncB == filt) begin
        cnt <= '0;                     // bounce restarts the window (R8)
      end else if (tick) begin
        if (cntNext >= limit) begin
          filt <= syncB;
          cnt  <= '0;
        end else begin
          cnt <= cntNext;
        end
      end
    end
  end

  a_r8_agree_holds: assert property (@(posedge clk) disable iff (!rstN)
    (syncB == filt) |=> $stable(filt));

  a_r9_no_tick_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!seed && !tick) |=> $stable(filt));

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt < CNT_W'(MAX_TICKS));

endmodule

// File: rtl/dbf_datapath.sv
module dbf_datapath
  import dbf_pkg::*;
#(
  parameter int NUM_PINS     = 12,
  parameter int DEFAULT_CODE = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  dbfStrobe_t          strb,
  input  logic [31:0]         wdata,
  input  logic [NUM_PINS-1:0] pinRaw,
  output logic [31:0]         rdata,
  output logic [NUM_PINS-1:0] pinFilt
);

  logic [2:0]  cfgCode [NUM_PINS];
  logic [31:0] rdWord;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int REG = p / 8;
    localparam int BIT = (p % 8) * 4;
    logic fieldHit;

    assign fieldHit = strb.cfgWrite && (strb.regIdx == 8'(REG)) && wdata[BIT+3];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         cfgCode[p] <= 3'(DEFAULT_CODE);
      else if (fieldHit) cfgCode[p] <= wdata[BIT +: 3];
    end

    dbf_channel u_chan (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (pinRaw[p]),
      .tick  (strb.tick),
      .seed  (strb.seed),
      .code  (cfgCode[p]),
      .filt  (pinFilt[p])
    );

    a_r3_masked_field_kept: assert property (@(posedge clk) disable iff (!rstN)
      (strb.cfgWrite && strb.regIdx == 8'(REG) && !wdata[BIT+3]) |=> $stable(cfgCode[p]));

    a_r3_foreign_word_kept: assert property (@(posedge clk) disable iff (!rstN)
      (strb.regIdx != 8'(REG)) |=> $stable(cfgCode[p]));
  end

  always_comb begin
    rdWord = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if ((p / 8) == int'(strb.regIdx)) rdWord[(p % 8) * 4 +: 3] = cfgCode[p];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdata <= '0;
    else if (strb.cfgRead) rdata <= rdWord;
  end

  a_r4_rdata_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgRead |=> $stable(rdata));

endmodule

// File: rtl/dbf_bank.sv
module dbf_bank
  import dbf_pkg::*;
#(
  parameter int NUM_PINS     = 12,
  parameter int CLK_HZ       = 1_000_000,
  parameter int ADDR_W       = 4,
  parameter int DEFAULT_CODE = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinRaw,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic [NUM_PINS-1:0] pinFilt
);

  localparam int NUM_REGS = (NUM_PINS + 7) / 8;

  dbfStrobe_t strb;

  dbf_ctrl #(
    .CLK_HZ   (CLK_HZ),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  dbf_datapath #(
    .NUM_PINS     (NUM_PINS),
    .DEFAULT_CODE (DEFAULT_CODE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (busWdata),
    .pinRaw  (pinRaw),
    .rdata   (busRdata),
    .pinFilt (pinFilt)
  );

endmodule

// File: tb/dbf_bank_tb.sv
module dbf_bank_tb;

  localparam int NP = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinRaw = '0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [3:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [NP-1:0] pinFilt;

  int vectors = 0;
  int misses = 0;
  bit summaryDone = 1'b0;

  logic [31:0]   expQ[$];
  string         tagQ[$];
  logic          rdPendQ = 1'b0;
  logic [NP-1:0] expFilt;

  always #2.5 clk = ~clk;   // 200 MHz

  dbf_bank #(
    .NUM_PINS (NP),
    .CLK_HZ   (1_000_000),
    .ADDR_W   (4),
    .DEFAULT_CODE (3)
  ) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .pinRaw   (pinRaw),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinFilt  (pinFilt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares
  always @(posedge clk) rdPendQ <= busSel && !busWrite;
  always @(negedge clk) begin
    if (rdPendQ && expQ.size() > 0) begin
      string t;
      logic [31:0] e;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, busRdata, e);
    end
  end

  task automatic busWr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  // flip one pin, check one edge before and exactly on the L+2 edge
  task automatic edgeTest(input int pin, input int ticks, input string t);
    @(negedge clk);
    pinRaw[pin] = ~pinRaw[pin];
    repeat (ticks + 1) @(negedge clk);
    check({t, " hold"}, 32'(pinFilt), 32'(expFilt));
    expFilt[pin] = pinRaw[pin];
    @(negedge clk);
    check({t, " flip"}, 32'(pinFilt), 32'(expFilt));
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    pinRaw = 12'h005;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    expFilt = 12'h005;
    check("R1 seed level", 32'(pinFilt), 32'(expFilt));

    busRd(4'd0, 32'h3333_3333, "R1 R2 reset word0");
    busRd(4'd1, 32'h0000_3333, "R4 partial word1");
    busRd(4'd5, 32'h0000_0000, "R4 unused addr");

    busWr(4'd0, 32'h0000_0078);            // pin0 -> 0 enabled, pin1 -> 7 masked
    busRd(4'd0, 32'h3333_3330, "R3 single field");
    busWr(4'd0, 32'h00EF_0A90);            // pin1 1, pin2 2, pin4 7, pin5 6
    busRd(4'd0, 32'h3367_3210, "R2 R6 field layout");
    busWr(4'd5, 32'hFFFF_FFFF);
    busRd(4'd0, 32'h3367_3210, "R3 unused addr write word0");
    busRd(4'd1, 32'h0000_3333, "R3 unused addr write word1");
    busWr(4'd1, 32'hFFFF_FFFF);
    busRd(4'd1, 32'h0000_7777, "R4 enable bits read 0");

    edgeTest(0, 1, "R5 R7 R9 code0");
    edgeTest(1, 10, "R5 R7 code1");
    edgeTest(2, 100, "R5 R7 code2");
    edgeTest(3, 1000, "R5 R7 code3");

    // bounce restart on pin3 (1000 ticks), back down to 0
    @(negedge clk);
    pinRaw[3] = 1'b0;
    repeat (500) @(negedge clk);
    check("R8 mid-window hold", 32'(pinFilt), 32'(expFilt));
    pinRaw[3] = 1'b1;
    @(negedge clk);
    pinRaw[3] = 1'b0;
    repeat (1001) @(negedge clk);
    check("R8 restarted hold", 32'(pinFilt), 32'(expFilt));
    expFilt[3] = 1'b0;
    @(negedge clk);
    check("R8 restarted flip", 32'(pinFilt), 32'(expFilt));

    edgeTest(5, 30000, "R5 code6");
    edgeTest(4, 30000, "R6 code7");

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule